// File: doc/BRIEF.md
# Two-Wire Target Byte Receiver

This block is the receive front end of a two-wire serial target such as a serial memory. A fast system clock samples the open-drain clock line (SCL) and data line (SDA). Each line passes through a synchroniser and then a digital glitch filter, which rejects pulses no longer than a configurable number of system clocks. From the filtered lines the block detects bus start and stop conditions. Once a start has been seen, it shifts in 8-bit words most significant bit first.

After the eighth bit the block acknowledges by asserting an active-low output enable on SDA for the ninth clock. It never drives the line high. When the ninth clock falls it releases the line and presents the received byte with a one-cycle strobe. A start that arrives mid-word discards the partial word, and a repeated start without a stop is accepted.

A standby flag reports whether the target is idle. The flag is set at reset. It is set again after a stop, once the internal-busy input is low.

Top module: `twi_target_rx`

## Requirements
- R1: During and directly after reset, `sda_oe` is 0, `byte_valid` is 0 and `standby` is 1.
- R2: A pulse on `scl_in` or `sda_in` lasting `FILT_CYCLES` system clocks or fewer has no effect. It adds no bit and creates no start or stop.
- R3: SCL activity is ignored until a start is seen. A start is SDA falling while SCL is high, and before it no acknowledge is driven and no byte is reported.
- R4: Data bits are sampled on the filtered SCL rising edge and assembled with the first bit as the MSB, `byte_data[7]`.
- R5: `sda_oe` rises only after the falling SCL edge that ends the eighth bit. It stays high through the ninth clock and falls after that clock's falling edge. At every other time it is 0.
- R6: Each acknowledged word produces exactly one `byte_valid` pulse, one cycle wide, in the cycle `sda_oe` is released, with the word on `byte_data`.
- R7: A start that arrives after fewer than eight bits discards those bits. No byte is reported for them, and the next eight bits form a complete word.
- R8: A repeated start without a stop is accepted, and the words after it are received normally.
- R9: A stop (SDA rising while SCL is high) returns the block to idle. Later SCL pulses without a new start are not acknowledged.
- R10: A start clears `standby`. After a stop, `standby` returns to 1 only once `busy_in` is low, and it stays 0 while `busy_in` remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| busy_in | input | 1 | High while an internal operation is in progress |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| byte_valid | output | 1 | One-cycle strobe for a received word |
| byte_data | output | 8 | Received word, valid with `byte_valid` |
| standby | output | 1 | Target is idle in standby |

## Verification
The assertions check several properties on every cycle:
- the strobe is a single cycle and coincides with the release of the acknowledge;
- the enable rises only just after a filtered SCL fall;
- a start clears the enable, the strobe and standby;
- standby rises only when the busy input was low.

Some behaviours only the bench's scenarios can show. These are the bit order, glitch rejection on either line, the discarding of a partial word on a mid-word start, silence before the first start and after a stop, and the correct byte values. The bench shows them by driving whole bus transactions against a queue of expected words.

// File: rtl/twi_rx_pkg.sv
package twi_rx_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_DATA = 2'd1,
        RX_ACK  = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic [BYTE_BITS-1:0] shift_msb_first(
        input logic [BYTE_BITS-1:0] cur,
        input logic                 bit_in
    );
        return {cur[BYTE_BITS-2:0], bit_in};
    endfunction

endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
    parameter int FILT_CYCLES = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_CYCLES + 2);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_cnt;
    logic                   level_q;
    logic                   sampled;

    assign sampled = sync_q[SYNC_STAGES-1];
    assign dout    = level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            run_cnt <= '0;
            level_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            if (sampled == level_q) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(FILT_CYCLES)) begin
                level_q <= sampled;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect
    import twi_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        evt.start    = scl_f & scl_q & sda_q & ~sda_f;
        evt.stop     = scl_f & scl_q & ~sda_q & sda_f;
        evt.scl_rise = scl_f & ~scl_q;
        evt.scl_fall = ~scl_f & scl_q;
        evt.sda      = sda_f;
    end

endmodule

// File: rtl/twi_byte_shifter.sv
module twi_byte_shifter
    import twi_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  bus_evt_t             evt,
    output logic                 sda_oe,
    output logic                 byte_valid,
    output logic [BYTE_BITS-1:0] byte_data
);
    localparam int BCW = $clog2(BYTE_BITS + 1);

    rx_state_e            state;
    logic [BCW-1:0]       bit_cnt;
    logic [BYTE_BITS-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            sda_oe     <= 1'b0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (evt.start) begin
                state   <= RX_DATA;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (evt.stop) begin
                state   <= RX_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state)
                    RX_DATA: begin
                        if (evt.scl_rise && bit_cnt != BCW'(BYTE_BITS)) begin
                            shreg   <= shift_msb_first(shreg, evt.sda);
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (evt.scl_fall && bit_cnt == BCW'(BYTE_BITS)) begin
                            sda_oe  <= 1'b1;
                            bit_cnt <= '0;
                            state   <= RX_ACK;
                        end
                    end
                    RX_ACK: begin
                        if (evt.scl_fall) begin
                            sda_oe     <= 1'b0;
                            byte_valid <= 1'b1;
                            byte_data  <= shreg;
                            state      <= RX_DATA;
                        end
                    end
                    default: begin
                        bit_cnt <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/twi_standby_ctl.sv
module twi_standby_ctl (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    input  logic busy_in,
    output logic standby
);
    logic sleep_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            standby    <= 1'b1;
            sleep_pend <= 1'b0;
        end else if (start) begin
            standby    <= 1'b0;
            sleep_pend <= 1'b0;
        end else if (stop || sleep_pend) begin
            if (!busy_in) begin
                standby    <= 1'b1;
                sleep_pend <= 1'b0;
            end else begin
                sleep_pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/twi_target_rx.sv
module twi_target_rx
    import twi_rx_pkg::*;
#(
    parameter int FILT_CYCLES = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       busy_in,
    output logic       sda_oe,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       standby
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    bus_evt_t           evt;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        twi_glitch_filter #(
            .FILT_CYCLES(FILT_CYCLES),
            .SYNC_STAGES(SYNC_STAGES)
        ) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    twi_cond_detect u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_f (filt_lines[0]),
        .sda_f (filt_lines[1]),
        .evt   (evt)
    );

    twi_byte_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .sda_oe     (sda_oe),
        .byte_valid (byte_valid),
        .byte_data  (byte_data)
    );

    twi_standby_ctl u_stby (
        .clk     (clk),
        .rst     (rst),
        .start   (evt.start),
        .stop    (evt.stop),
        .busy_in (busy_in),
        .standby (standby)
    );

endmodule

// File: rtl/twi_target_rx_checker.sv
module twi_target_rx_checker
    import twi_rx_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     busy_in,
    input logic     sda_oe,
    input logic     byte_valid,
    input logic     standby,
    input bus_evt_t evt
);
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            a_r1_reset_state: assert (!sda_oe && !byte_valid && standby)
                else $error("R1 reset state wrong");
        end
    end

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    a_r6_with_release: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> $fell(sda_oe));

    a_r5_ack_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(evt.scl_fall));

    a_r5_no_ack_in_standby: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> !standby);

    a_r7_start_aborts: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (!sda_oe && !byte_valid));

    a_r10_start_wakes: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> !standby);

    a_r10_sleep_not_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(standby) |-> !$past(busy_in));

endmodule

bind twi_target_rx twi_target_rx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_in    (busy_in),
    .sda_oe     (sda_oe),
    .byte_valid (byte_valid),
    .standby    (standby),
    .evt        (evt)
);

// File: tb/twi_target_rx_tb.sv
module twi_target_rx_tb;

    localparam int FILT = 7;
    localparam int H    = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_gl = 1'b0, sda_gl = 1'b0;
    logic       busy_in = 1'b0;
    logic       sda_oe, byte_valid, standby;
    logic [7:0] byte_data;
    logic       scl_in, sda_in;

    int checks = 0;
    int errors = 0;
    int stray_oe = 0;
    int valid_seen = 0;
    int valid_exp = 0;
    bit ack_win = 1'b0;
    bit prev_valid = 1'b0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    assign scl_in = scl_m ^ scl_gl;
    assign sda_in = (sda_m & ~sda_oe) ^ sda_gl;

    always #4 clk = ~clk;

    twi_target_rx #(.FILT_CYCLES(FILT), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .busy_in(busy_in), .sda_oe(sda_oe), .byte_valid(byte_valid),
        .byte_data(byte_data), .standby(standby)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // per-clock reference comparison
    always @(negedge clk) begin
        if (!rst) begin
            if (sda_oe && !ack_win) stray_oe++;
            if (byte_valid) begin
                valid_seen++;
                checks++;
                if (prev_valid) begin
                    errors++;
                    $display("FAIL R6 strobe wider than one cycle actual=1 expected=0");
                end else if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R6 unexpected byte actual=%0h expected=none", byte_data);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    if (byte_data !== e) begin
                        errors++;
                        $display("FAIL R4 byte data actual=%0h expected=%0h", byte_data, e);
                    end
                end
            end
            prev_valid = byte_valid;
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; wclk(2*H);
        scl_m = 1'b1; wclk(2*H);
        sda_m = 1'b0; wclk(2*H);
        scl_m = 1'b0; wclk(2*H);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; wclk(H);
        sda_m = 1'b0; wclk(2*H);
        scl_m = 1'b1; wclk(2*H);
        sda_m = 1'b1; wclk(2*H);
    endtask

    // gl: 0 none, 1 SCL dip during bit 4 high, 2 SDA dip during bit 6 high
    task automatic clock_bits(input logic [7:0] b, input int n, input bit ack, input int gl);
        scl_m = 1'b0; wclk(H);
        for (int i = 7; i >= 8 - n; i--) begin
            sda_m = b[i]; wclk(H);
            scl_m = 1'b1; wclk(H/2);
            if ((gl == 1 && i == 4) || (gl == 2 && i == 6)) begin
                if (gl == 1) scl_gl = 1'b1; else sda_gl = 1'b1;
                wclk(FILT);
                scl_gl = 1'b0; sda_gl = 1'b0;
                wclk(2*H - H/2 - FILT);
            end else begin
                wclk(2*H - H/2);
            end
            if (i == 0 && n == 8) ack_win = ack;
            scl_m = 1'b0; wclk(H);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit ack, input int gl);
        clock_bits(b, 8, ack, gl);
        sda_m = 1'b1; wclk(H);
        check(sda_oe == ack, "R5 ack driven in ninth clock low", sda_oe, ack);
        scl_m = 1'b1; wclk(2*H);
        check(sda_oe == ack, "R5 ack held in ninth clock high", sda_oe, ack);
        if (ack) begin
            exp_q.push_back(b);
            valid_exp++;
        end
        scl_m = 1'b0; wclk(H);
        check(sda_oe == 1'b0, "R5 ack released after ninth fall", sda_oe, 0);
        ack_win = 1'b0;
    endtask

    initial begin
        wclk(5);
        check(sda_oe == 0 && byte_valid == 0, "R1 outputs idle in reset", {sda_oe, byte_valid}, 0);
        rst = 1'b0;
        wclk(2);
        check(standby == 1'b1, "R1 standby after reset", standby, 1);
        check(sda_oe == 1'b0, "R1 no drive after reset", sda_oe, 0);

        // R3: clocking before any start is ignored
        send_byte(8'hA5, 1'b0, 0);
        check(valid_seen == 0, "R3 no byte before start", valid_seen, 0);

        bus_start();
        check(standby == 1'b0, "R10 start clears standby", standby, 0);
        send_byte(8'hC3, 1'b1, 0);   // R4 MSB first
        send_byte(8'h3C, 1'b1, 0);
        send_byte(8'h81, 1'b1, 1);   // R2 SCL glitch
        send_byte(8'h5D, 1'b1, 2);   // R2 SDA glitch, bit6=1
        check(valid_seen == 4, "R2 glitches left bytes intact", valid_seen, 4);

        // R7: partial word aborted by start
        clock_bits(8'hE7, 4, 1'b0, 0);
        bus_start();
        send_byte(8'h5A, 1'b1, 0);
        check(valid_seen == 5, "R7 partial word discarded", valid_seen, 5);

        // R8: repeated start
        bus_start();
        send_byte(8'h96, 1'b1, 0);
        check(valid_seen == 6, "R8 byte after repeated start", valid_seen, 6);

        // R10: standby held while busy
        busy_in = 1'b1;
        bus_stop();
        wclk(50);
        check(standby == 1'b0, "R10 standby held off while busy", standby, 0);
        busy_in = 1'b0;
        wclk(4);
        check(standby == 1'b1, "R10 standby after busy clears", standby, 1);

        // R9: clocks after stop are ignored
        send_byte(8'h66, 1'b0, 0);
        check(valid_seen == 6, "R9 no byte after stop", valid_seen, 6);
        check(standby == 1'b1, "R9 standby kept without start", standby, 1);

        bus_start();
        send_byte(8'h00, 1'b1, 0);
        send_byte(8'hFF, 1'b1, 0);
        bus_stop();
        wclk(10);

        check(exp_q.size() == 0, "R6 every expected byte reported", exp_q.size(), 0);
        check(valid_seen == valid_exp, "R6 one strobe per word", valid_seen, valid_exp);
        check(stray_oe == 0, "R5 no drive outside ack", stray_oe, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule